// File: doc/BRIEF.md
# Irregular Sequence Counter

A 3-bit synchronous counter that walks a fixed loop of five codes instead of binary order. Each rising clock edge with the enable high moves the output one step along the loop 000, 010, 011, 101, 110 and then back to 000. The codes 001, 100 and 111 are not in the loop. If the register ever holds one of them, the next enabled edge returns it to 000, so the counter cannot lock up outside the loop.

The state register drives the output directly, with no decoding after it. A synchronous reset loads a start code. That code is a parameter and is 000 by default. The block suits any controller that needs a short, repeating, non-binary step pattern from a register with few flip-flops.

Top module: `irr_seq_counter`

## Requirements
- R1: At a rising clock edge with `rst` high, `code` becomes `RESET_CODE` (default 000), whatever the value of `en`.
- R2: At a rising clock edge with `rst` low and `en` high, `code` steps 000 to 010, 010 to 011, 011 to 101, and 101 to 110.
- R3: At a rising clock edge with `rst` low and `en` high, `code` 110 steps to 000, which closes the five-code loop.
- R4: At a rising clock edge with `rst` low and `en` high, any of the unused codes 001, 100 or 111 goes to 000.
- R5: At a rising clock edge with `rst` low and `en` low, `code` keeps its value. This also holds for an unused code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all changes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high; loads `RESET_CODE` |
| en | input | 1 | Count enable, active high |
| code | output | 3 | Current state of the counter, which is also its output |

## Verification
The hardest case to reach is recovery from an unused code. No sequence of enable and reset at the ports can put the register into 001, 100 or 111. To reach those codes, the bench runs three extra instances with `RESET_CODE` set to each unused value. It resets them, holds them with the enable low, and then releases one enabled edge, expecting 000 on every instance. All four instances then share a long stretch of mixed enable and reset activity, and each one is checked against a reference model of the loop at every edge.

// File: rtl/irr_seq_counter.sv
module irr_seq_counter #(
  parameter logic [2:0] RESET_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] code
);

  logic [2:0] state_q;
  logic [2:0] step;

  always_comb begin
    unique case (state_q)
      3'b000:  step = 3'b010;
      3'b010:  step = 3'b011;
      3'b011:  step = 3'b101;
      3'b101:  step = 3'b110;
      default: step = 3'b000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     state_q <= RESET_CODE;
    else if (en) state_q <= step;
  end

  assign code = state_q;

endmodule

// File: rtl/irr_seq_counter_chk.sv
module irr_seq_counter_chk #(
  parameter logic [2:0] RESET_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] code
);

  // R1
  reset_load_chk: assert property (@(posedge clk) rst |=> code == RESET_CODE);

  // R2
  loop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && code == 3'b000) |=> code == 3'b010);

  // R2
  loop_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (code == 3'b011)) |=> code == 3'b101);

  // R3
  loop_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && code == 3'b110) |=> code == 3'b000);

  // R4
  unused_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (code == 3'b001 || code == 3'b100 || code == 3'b111)) |=> code == 3'b000);

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(code));

endmodule

bind irr_seq_counter irr_seq_counter_chk #(.RESET_CODE(RESET_CODE)) u_chk (
  .clk(clk), .rst(rst), .en(en), .code(code)
);

// File: tb/irr_seq_counter_bench.sv
`timescale 1ns/1ps
module irr_seq_counter_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2:0] q [4];
  logic [2:0] exp_q [4];
  logic [2:0] init_q [4];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  irr_seq_counter u_irr_seq_counter (.clk(clk), .rst(rst), .en(en), .code(q[0]));
  irr_seq_counter #(.RESET_CODE(3'b001)) u_irr_seq_counter_u1 (.clk(clk), .rst(rst), .en(en), .code(q[1]));
  irr_seq_counter #(.RESET_CODE(3'b100)) u_irr_seq_counter_u4 (.clk(clk), .rst(rst), .en(en), .code(q[2]));
  irr_seq_counter #(.RESET_CODE(3'b111)) u_irr_seq_counter_u7 (.clk(clk), .rst(rst), .en(en), .code(q[3]));

  function automatic logic [2:0] ref_next(input logic [2:0] c);
    logic [2:0] loop_codes [5];
    loop_codes = '{3'd0, 3'd2, 3'd3, 3'd5, 3'd6};
    for (int i = 0; i < 5; i++)
      if (loop_codes[i] == c) return loop_codes[(i + 1) % 5];
    return 3'd0;
  endfunction

  function automatic string req_of(input logic r, input logic e, input logic [2:0] c);
    if (r) return "R1";
    if (!e) return "R5";
    if (c == 3'd1 || c == 3'd4 || c == 3'd7) return "R4";
    if (c == 3'd6) return "R3";
    return "R2";
  endfunction

  task automatic apply(input logic r, input logic e);
    string tag;
    @(negedge clk);
    rst = r;
    en  = e;
    @(posedge clk);
    #1;
    for (int k = 0; k < 4; k++) begin
      tag = req_of(r, e, exp_q[k]);
      if (r)      exp_q[k] = init_q[k];
      else if (e) exp_q[k] = ref_next(exp_q[k]);
      n_checks++;
      if (q[k] !== exp_q[k]) begin
        n_fail++;
        $display("FAIL %s inst %0d: code=%b expected=%b", tag, k, q[k], exp_q[k]);
      end
    end
  endtask

  initial begin
    logic [7:0] lfsr;
    init_q = '{3'd0, 3'd1, 3'd4, 3'd7};
    exp_q  = '{3'd0, 3'd0, 3'd0, 3'd0};
    // R1: reset loads each instance's start code
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b1);
    // R5: idle holds, including on unused codes
    repeat (3) apply(1'b0, 1'b0);
    // R4: one enabled edge recovers unused codes to 000
    apply(1'b0, 1'b1);
    // R2, R3: full loop twice
    repeat (10) apply(1'b0, 1'b1);
    // mixed enable pattern, R5 and R2/R3
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      apply(1'b0, lfsr[0]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    // R1: reset wins over enable mid-run, then recover again (R4)
    apply(1'b1, 1'b1);
    apply(1'b0, 1'b0);
    apply(1'b0, 1'b1);
    repeat (7) apply(1'b0, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule